// File: doc/BRIEF.md
# Synchronous Queue with Last-Entry Overwrite

This block is a single-clock first-in first-out queue. Its data width is a parameter, and its depth may be any positive value, including values that are not a power of two. A producer offers a word with `push_en`. If `push_overwrite` is also high, the word replaces the entry that was written most recently, and no new slot is used. A consumer takes the head entry with `pop_en`. The block reports whether a pop can be accepted (`has_data`), whether a push can be accepted (`has_space`) and how many entries it holds (`count`).

The parameter `FWFT` selects the read mode.
- With `FWFT` set, the head entry is always visible on `pop_data`, and a pop discards it.
- With `FWFT` clear, `pop_data` is a register. It loads the head entry only on the edge that accepts a pop, and keeps its value at all other times.

The occupancy is tracked by a small state machine with three states:
- `OCC_EMPTY`: the queue holds nothing.
- `OCC_PARTIAL`: the queue holds between one entry and one short of the depth.
- `OCC_FULL`: the queue holds as many entries as its depth.

Its transitions are:
- *fill-first*: EMPTY to PARTIAL on an accepted push. When the depth is 1, this push goes straight to FULL.
- *fill-last*: PARTIAL to FULL on an accepted push with no pop, when the count is one short of the depth.
- *drain-last*: PARTIAL to EMPTY on an accepted pop with no push, when the count is 1.
- *drain-first*: FULL to PARTIAL on an accepted pop. When the depth is 1, this pop goes straight to EMPTY.

In every other case the state stays where it is.

Top module: `fifo_replace_q`

## Requirements
- R1: On the first clock edge after `rst` is released, `count` is 0, `has_data` is low and `has_space` is high.
- R2: At each edge, `count` changes as follows:
  - it rises by one if the edge accepts a push, meaning `push_en & ~push_overwrite & has_space`;
  - it falls by one if the edge accepts a pop, meaning `pop_en & has_data`;
  - it does both when both apply.
- R3: A push with `push_overwrite` high, while the queue holds at least one entry, replaces the most recently written entry with `push_data` and leaves `count` unchanged.
- R4: A push with `push_overwrite` high on an empty queue is ignored. The count stays 0, and later pushes are unaffected.
- R5: `has_data` is high exactly when `count` is nonzero, and `has_space` is high exactly when `count` is below the depth.
- R6: A push without overwrite while `has_space` is low is ignored. The count and the stored entries are unchanged.
- R7: A pop while `has_data` is low is ignored, and the count stays 0.
- R8: With `FWFT` set, `pop_data` always shows the oldest entry. When `count` is 1 just after an edge that accepted a push or an overwrite, `pop_data` equals the `push_data` offered at that edge.
- R9: With `FWFT` clear, `pop_data` loads the oldest entry on the edge that accepts a pop. It keeps its value after any edge at which `pop_en` was low. Its reset value is 0.
- R10: Entries leave in the order they were accepted. This holds when the pointers wrap at a depth that is not a power of two, for example 5.
- R11: An overwrite is honoured when the queue is full, even though `has_space` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push_en | input | 1 | Offer `push_data` |
| push_overwrite | input | 1 | With `push_en`, replace the last written entry |
| push_data | input | WIDTH | Data word to store |
| pop_en | input | 1 | Take the oldest entry |
| pop_data | output | WIDTH | Oldest entry (FWFT) or last popped entry (standard mode) |
| has_data | output | 1 | A pop would be accepted |
| has_space | output | 1 | A push without overwrite would be accepted |
| count | output | $clog2(DEPTH+1) | Number of stored entries |

## Verification
The results fall due at different times:
- `count`, `has_data` and `has_space` follow one edge after the stimulus that changes them.
- In FWFT mode, `pop_data` follows the head combinationally, so a new head is visible right after the edge that wrote it or that popped the previous one.
- In standard mode, `pop_data` changes on the edge that accepts the pop.

The bench drives inputs at the falling edge and checks the flags, the count and the FWFT head a quarter period later, before the next rising edge. An expected standard-mode word is queued at the accepting rising edge and compared at the following falling edge; when no word is due at that edge, the bench checks that `pop_data` held its previous value.

// File: rtl/fifo_q_pkg.sv
package fifo_q_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_t;

    // Index width for n slots; at least one bit.
    function automatic int idx_bits(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/fifo_q_ptr.sv
module fifo_q_ptr #(
    parameter int DEPTH = 5,
    parameter int AW    = fifo_q_pkg::idx_bits(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [AW-1:0] ptr,
    output logic [AW-1:0] ptr_prev
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    // Slot written just before the current one, with wrap at any depth.
    always_comb begin
        ptr_prev = (ptr == '0) ? LAST : ptr - 1'b1;
    end

    // R10: the wrap keeps the index inside the storage range.
    assert_ptr_in_range_R10: assert property (@(posedge clk) disable iff (rst)
        ptr <= LAST);

endmodule

// File: rtl/fifo_q_store.sv
module fifo_q_store #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 5,
    parameter int AW    = fifo_q_pkg::idx_bits(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slots[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        rd_data = slots[rd_addr];
    end

endmodule

// File: rtl/fifo_q_rdout.sv
module fifo_q_rdout #(
    parameter int WIDTH = 8,
    parameter bit FWFT  = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pop_ok,
    input  logic [WIDTH-1:0] head,
    output logic [WIDTH-1:0] dout
);
    generate
        if (FWFT) begin : g_show_ahead
            always_comb begin
                dout = head;
            end
        end else begin : g_registered
            always_ff @(posedge clk) begin
                if (rst) begin
                    dout <= '0;
                end else if (pop_ok) begin
                    dout <= head;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/fifo_replace_q.sv
module fifo_replace_q #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 5,
    parameter bit FWFT  = 1'b1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_en,
    input  logic             push_overwrite,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop_en,
    output logic [WIDTH-1:0] pop_data,
    output logic             has_data,
    output logic             has_space,
    output logic [LW-1:0]    count
);
    import fifo_q_pkg::*;

    localparam int            AW     = idx_bits(DEPTH);
    localparam logic [LW-1:0] CAP    = LW'(DEPTH);
    localparam logic [LW-1:0] CAP_M1 = LW'(DEPTH - 1);

    occ_state_t state_q, state_d;

    logic             push_ok, repl_ok, pop_ok;
    logic [AW-1:0]    wr_ptr, wr_prev, rd_ptr, wr_addr;
    logic [WIDTH-1:0] head_word;

    // Acceptance of each request
    always_comb begin
        push_ok = push_en & ~push_overwrite & has_space;
        repl_ok = push_en & push_overwrite & has_data;
        pop_ok  = pop_en & has_data;
        wr_addr = repl_ok ? wr_prev : wr_ptr;
    end

    fifo_q_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wr_ptr (
        .clk(clk), .rst(rst), .adv(push_ok),
        .ptr(wr_ptr), .ptr_prev(wr_prev)
    );

    logic [AW-1:0] rd_prev_unused;
    fifo_q_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rd_ptr (
        .clk(clk), .rst(rst), .adv(pop_ok),
        .ptr(rd_ptr), .ptr_prev(rd_prev_unused)
    );

    fifo_q_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk(clk), .wr_en(push_ok | repl_ok), .wr_addr(wr_addr),
        .wr_data(push_data), .rd_addr(rd_ptr), .rd_data(head_word)
    );

    fifo_q_rdout #(.WIDTH(WIDTH), .FWFT(FWFT)) u_rdout (
        .clk(clk), .rst(rst), .pop_ok(pop_ok),
        .head(head_word), .dout(pop_data)
    );

    // Occupancy counter
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Occupancy state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= OCC_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Occupancy transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (push_ok) begin
                    state_d = (DEPTH == 1) ? OCC_FULL : OCC_PARTIAL;
                end
            end
            OCC_PARTIAL: begin
                if (push_ok && !pop_ok && count == CAP_M1) begin
                    state_d = OCC_FULL;
                end else if (pop_ok && !push_ok && count == LW'(1)) begin
                    state_d = OCC_EMPTY;
                end
            end
            OCC_FULL: begin
                if (pop_ok && !push_ok) begin
                    state_d = (DEPTH == 1) ? OCC_EMPTY : OCC_PARTIAL;
                end
            end
            default: state_d = OCC_EMPTY;
        endcase
    end

    // Flags from the state
    always_comb begin
        has_data  = (state_q != OCC_EMPTY);
        has_space = (state_q != OCC_FULL);
    end

    // ---------------- assertions ----------------
    assert_reset_state_R1: assert property (@(posedge clk)
        (!rst && $past(rst)) |-> (count == '0 && !has_data && has_space));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> int'(count) == int'($past(count))
            + int'($past(push_en && !push_overwrite && has_space))
            - int'($past(pop_en && has_data)));

    assert_overwrite_keeps_count_R3: assert property (@(posedge clk) disable iff (rst)
        (push_en && push_overwrite && !pop_en) |=> $stable(count));

    assert_overwrite_empty_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (push_en && push_overwrite && !has_data) |=> (count == '0));

    assert_flags_match_count_R5: assert property (@(posedge clk) disable iff (rst)
        (has_data == (count != '0)) && (has_space == (count != CAP)));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        count <= CAP);

    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
        (pop_en && !has_data && !push_en) |=> (count == '0));

    generate
        if (FWFT) begin : g_chk_fwft
            assert_fwft_single_head_R8: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && count == LW'(1)
                 && $past(push_en && (has_space || push_overwrite)))
                |-> (pop_data == $past(push_data)));
        end else begin : g_chk_std
            assert_std_hold_R9: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && !$past(pop_en)) |-> $stable(pop_data));
        end
    endgenerate

endmodule

// File: tb/fifo_replace_q_test.sv
`timescale 1ns/1ps
module fifo_replace_q_test;
    localparam int W  = 8;
    localparam int D  = 5;
    localparam int LW = $clog2(D + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;   // 50 MHz

    logic          push_en = 0, push_ow = 0, pop_en = 0;
    logic [W-1:0]  push_data = '0;
    logic [W-1:0]  f_data, s_data;
    logic          f_hd, f_hs, s_hd, s_hs;
    logic [LW-1:0] f_cnt, s_cnt;

    fifo_replace_q #(.WIDTH(W), .DEPTH(D), .FWFT(1'b1)) uut (
        .clk(clk), .rst(rst), .push_en(push_en), .push_overwrite(push_ow),
        .push_data(push_data), .pop_en(pop_en), .pop_data(f_data),
        .has_data(f_hd), .has_space(f_hs), .count(f_cnt)
    );

    fifo_replace_q #(.WIDTH(W), .DEPTH(D), .FWFT(1'b0)) uut_std (
        .clk(clk), .rst(rst), .push_en(push_en), .push_overwrite(push_ow),
        .push_data(push_data), .pop_en(pop_en), .pop_data(s_data),
        .has_data(s_hd), .has_space(s_hs), .count(s_cnt)
    );

    int checks = 0;
    int bad    = 0;
    bit done   = 0;
    logic [W-1:0] mdl[$];      // model contents
    logic [W-1:0] std_q[$];    // scoreboard of due standard-mode words
    logic [W-1:0] std_last = '0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: one cycle of stimulus, checks before the edge, model update at the edge.
    task automatic step(input bit p, input bit ow, input bit q, input logic [W-1:0] d,
                        input string req);
        int sz;
        logic [W-1:0] head;
        bit p_ok, r_ok, q_ok;
        @(negedge clk);
        push_en = p; push_ow = ow; pop_en = q; push_data = d;
        #5;
        sz = mdl.size();
        chk(f_cnt == LW'(sz), {req, " R2 count fwft"}, f_cnt, sz);
        chk(s_cnt == LW'(sz), {req, " R2 count std"}, s_cnt, sz);
        chk(f_hd == (sz > 0) && s_hd == (sz > 0), {req, " R5 has_data"}, f_hd, sz > 0);
        chk(f_hs == (sz < D) && s_hs == (sz < D), {req, " R5 has_space"}, f_hs, sz < D);
        head = (sz > 0) ? mdl[0] : '0;
        if (sz > 0) chk(f_data == head, {req, " R8 fwft head"}, f_data, head);
        p_ok = p && !ow && sz < D;
        r_ok = p && ow && sz > 0;
        q_ok = q && sz > 0;
        @(posedge clk);
        if (r_ok) mdl[sz - 1] = d;
        if (q_ok) begin
            void'(mdl.pop_front());
            std_q.push_back(head);
        end
        if (p_ok) mdl.push_back(d);
    endtask

    // Monitor for the registered read mode (R9)
    always @(negedge clk) begin
        if (!rst && !done) begin
            #2;
            if (std_q.size() > 0) begin
                std_last = std_q.pop_front();
                chk(s_data == std_last, "R9 std data after pop", s_data, std_last);
            end else begin
                chk(s_data == std_last, "R9 std data held", s_data, std_last);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        @(negedge clk);
        #5;
        chk(f_cnt == 0 && s_cnt == 0, "R1 count after reset", f_cnt, 0);
        chk(!f_hd && !s_hd, "R1 has_data after reset", f_hd, 0);
        chk(f_hs && s_hs, "R1 has_space after reset", f_hs, 1);

        // R7: pop on empty is ignored
        step(0, 0, 1, 8'h00, "R7");
        // R4: overwrite on empty is ignored
        step(1, 1, 0, 8'hEE, "R4");
        step(0, 0, 0, 8'h00, "R4 after");
        // R8: first word visible one edge after its push
        step(1, 0, 0, 8'h11, "R8");
        // R3: overwrite the single entry
        step(1, 1, 0, 8'h22, "R3 single");
        step(0, 0, 0, 8'h00, "R3 single after");
        // fill to full (R10 order, R6 overflow)
        for (int i = 0; i < 4; i++) step(1, 0, 0, W'(8'h30 + i), "R10 fill");
        step(1, 0, 0, 8'hFF, "R6 push when full");
        // R11: overwrite while full
        step(1, 1, 0, 8'h5A, "R11");
        step(0, 0, 0, 8'h00, "R11 after");
        // simultaneous push and pop across the wrap
        step(0, 0, 1, 8'h00, "R10 drain");
        for (int i = 0; i < 6; i++) step(1, 0, 1, W'(8'h60 + i), "R2 push+pop");
        // overwrite with a pop in the same cycle
        step(1, 1, 1, 8'h77, "R3 with pop");
        // drain fully, then an extra pop
        for (int i = 0; i < 6; i++) step(0, 0, 1, 8'h00, "R10 drain all");
        step(0, 0, 1, 8'h00, "R7 empty pop");
        // pseudo-random traffic
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[5], lfsr[1] & lfsr[2] & lfsr[3], lfsr[4] | lfsr[7],
                 lfsr[15:8], "R10 random");
        end
        step(0, 0, 0, 8'h00, "idle");
        step(0, 0, 0, 8'h00, "idle");
        @(negedge clk);
        #4;
        finish_run();
    end

endmodule